// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block services a translation miss. It walks a hierarchy of page tables held in main memory and produces the physical translation for a 32-bit virtual address. The walk starts from a root table base supplied with the request. The first table is indexed by the context number. The next three tables are indexed by fixed fields of the virtual address.

At each level the walker reads one 32-bit entry. That entry either points at the next table or ends the walk. A walk may end at any of the four levels. The level where it ends sets the page size: 4 GB, 16 MB, 256 KB or 4 KB. A walk that meets an unusable entry ends with a fault code instead of an address.

Memory is reached through a plain read port. The walker issues one read pulse and then waits for a single response word. Only one read is ever in flight.

Top module: `tablewalk_unit`

## Requirements
- R1: After reset, `req_ready` is 1, and `done` and `mem_req` are 0.
- R2: The first read of a walk goes to address `{root_ptr, 6'b0} + ctx*4`.
- R3: A table pointer read at level L (0..2) makes the next read go to `{entry[31:2], 6'b0} + idx*4`. The index is VA[31:24] at level 1, VA[23:18] at level 2 and VA[17:12] at level 3.
- R4: The entry type sits in entry[1:0]. Type 0 ends the walk with `fault`=1 and `fault_kind`=1. Type 3 ends it with `fault`=1 and `fault_kind`=2. `walk_level` reports the level of the entry that caused the fault.
- R5: A table pointer (type 1) read at level 3 ends the walk with `fault`=1, `fault_kind`=3 and `walk_level`=3.
- R6: A translation entry (type 2) ends the walk with `fault`=0, `fault_kind`=0 and `walk_level` set to its level. PA[35:12] comes from entry[31:8], except that the low PA bits are copied from the VA: VA[31:0] at level 0, VA[23:0] at level 1, VA[17:0] at level 2 and VA[11:0] at level 3.
- R7: On success, `attr` equals entry[7:2] of the translation entry.
- R8: `mem_req` is a one-cycle pulse. No new read is issued until the response to the previous read has arrived.
- R9: A request is taken only while `req_ready` is 1. `req_valid` held while the walker is busy starts no extra reads and does not change the result of the walk in progress.
- R10: `done` is a one-cycle pulse. A fault result carries `pa`=0 and `attr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_va | input | 32 | Virtual address to translate |
| req_ctx | input | CTX_W | Context number |
| root_ptr | input | 30 | Root table base, PA[35:6] |
| mem_req | output | 1 | Read pulse |
| mem_addr | output | 36 | Read byte address |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry read from memory |
| done | output | 1 | Walk finished, result valid |
| fault | output | 1 | Walk ended without a translation |
| fault_kind | output | 2 | 0 none, 1 invalid, 2 reserved type, 3 pointer at last level |
| walk_level | output | 2 | Level where the walk ended |
| pa | output | 36 | Physical address |
| attr | output | 6 | Attribute bits of the translation entry |

## Verification
A wrong level counter or a wrong base register shows up quickly. The read address of the very next level goes to the wrong table, so the error is visible one response later. It also appears in the page size applied to the final address.

A state machine that loses its place has two visible symptoms. It either issues a second read while one is still pending, or it raises `done` without a matching walk. Both are caught on the cycle they occur.

A wrong entry decode is visible in the `done` cycle of that walk. It shows as a wrong fault code, a wrong level or wrong attribute bits.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int VA_W    = 32;
  localparam int PA_W    = 36;
  localparam int ENT_W   = 32;
  localparam int ALIGN_W = 6;
  localparam int BASE_W  = PA_W - ALIGN_W;
  localparam int PPN_W   = 24;
  localparam int ATTR_W  = 6;
  localparam int LVL_W   = 2;

  typedef enum logic [1:0] {
    ENT_INVALID = 2'd0,
    ENT_PTR     = 2'd1,
    ENT_LEAF    = 2'd2,
    ENT_RSVD    = 2'd3
  } ent_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_INVALID = 2'd1,
    FLT_RSVD    = 2'd2,
    FLT_DEPTH   = 2'd3
  } flt_kind_e;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_WAIT = 1'b1
  } walk_state_e;
endpackage

// File: rtl/tw_addr_gen.sv
module tw_addr_gen
  import tw_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic [LVL_W-1:0]  level,
  input  logic [BASE_W-1:0] base,
  input  logic [CTX_W-1:0]  ctx,
  input  logic [VA_W-1:0]   va,
  output logic [PA_W-1:0]   addr
);
  localparam int IW = (CTX_W > 8) ? CTX_W : 8;

  logic [IW-1:0] idx;

  always_comb begin
    case (level)
      2'd0:    idx = IW'(ctx);
      2'd1:    idx = IW'(va[31:24]);
      2'd2:    idx = IW'(va[23:18]);
      default: idx = IW'(va[17:12]);
    endcase
    addr = {base, {ALIGN_W{1'b0}}} + PA_W'({idx, 2'b00});
  end
endmodule

// File: rtl/tw_entry_decode.sv
module tw_entry_decode
  import tw_pkg::*;
(
  input  logic [ENT_W-1:0]  entry,
  output ent_kind_e         kind,
  output logic [BASE_W-1:0] next_base,
  output logic [PPN_W-1:0]  ppn,
  output logic [ATTR_W-1:0] attr
);
  assign kind      = ent_kind_e'(entry[1:0]);
  assign next_base = entry[ENT_W-1:2];
  assign ppn       = entry[ENT_W-1:8];
  assign attr      = entry[7:2];
endmodule

// File: rtl/tw_pa_compose.sv
module tw_pa_compose
  import tw_pkg::*;
(
  input  logic [LVL_W-1:0] level,
  input  logic [PPN_W-1:0] ppn,
  input  logic [VA_W-1:0]  va,
  output logic [PA_W-1:0]  pa
);
  always_comb begin
    case (level)
      2'd0:    pa = {ppn[23:20], va[31:0]};
      2'd1:    pa = {ppn[23:12], va[23:0]};
      2'd2:    pa = {ppn[23:6],  va[17:0]};
      default: pa = {ppn,        va[11:0]};
    endcase
  end
endmodule

// File: rtl/tablewalk_unit.sv
module tablewalk_unit
  import tw_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_va,
  input  logic [CTX_W-1:0]  req_ctx,
  input  logic [29:0]       root_ptr,
  output logic              mem_req,
  output logic [35:0]       mem_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              done,
  output logic              fault,
  output logic [1:0]        fault_kind,
  output logic [1:0]        walk_level,
  output logic [35:0]       pa,
  output logic [5:0]        attr
);
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(3);

  walk_state_e       state;
  logic [VA_W-1:0]   va_q;
  logic [LVL_W-1:0]  lvl_q;

  ent_kind_e         ent_kind;
  logic [BASE_W-1:0] ent_base;
  logic [PPN_W-1:0]  ent_ppn;
  logic [ATTR_W-1:0] ent_attr;

  logic [LVL_W-1:0]  gen_level;
  logic [BASE_W-1:0] gen_base;
  logic [PA_W-1:0]   gen_addr;
  logic [PA_W-1:0]   leaf_pa;

  assign gen_level = (state == S_IDLE) ? '0 : lvl_q + 1'b1;
  assign gen_base  = (state == S_IDLE) ? root_ptr : ent_base;
  assign req_ready = (state == S_IDLE);

  tw_addr_gen #(.CTX_W(CTX_W)) u_addr (
    .level(gen_level), .base(gen_base), .ctx(req_ctx), .va(va_q), .addr(gen_addr)
  );

  tw_entry_decode u_dec (
    .entry(mem_rsp_data), .kind(ent_kind), .next_base(ent_base),
    .ppn(ent_ppn), .attr(ent_attr)
  );

  tw_pa_compose u_pa (
    .level(lvl_q), .ppn(ent_ppn), .va(va_q), .pa(leaf_pa)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      va_q       <= '0;
      lvl_q      <= '0;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
      done       <= 1'b0;
      fault      <= 1'b0;
      fault_kind <= FLT_NONE;
      walk_level <= '0;
      pa         <= '0;
      attr       <= '0;
    end else begin
      mem_req <= 1'b0;
      done    <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            va_q     <= req_va;
            lvl_q    <= '0;
            mem_req  <= 1'b1;
            mem_addr <= gen_addr;
            state    <= S_WAIT;
          end
        end
        default: begin
          if (mem_rsp_valid) begin
            if (ent_kind == ENT_PTR && lvl_q != LAST_LVL) begin
              lvl_q    <= lvl_q + 1'b1;
              mem_req  <= 1'b1;
              mem_addr <= gen_addr;
            end else begin
              done       <= 1'b1;
              walk_level <= lvl_q;
              state      <= S_IDLE;
              if (ent_kind == ENT_LEAF) begin
                fault      <= 1'b0;
                fault_kind <= FLT_NONE;
                pa         <= leaf_pa;
                attr       <= ent_attr;
              end else begin
                fault <= 1'b1;
                pa    <= '0;
                attr  <= '0;
                case (ent_kind)
                  ENT_INVALID: fault_kind <= FLT_INVALID;
                  ENT_RSVD:    fault_kind <= FLT_RSVD;
                  default:     fault_kind <= FLT_DEPTH;
                endcase
              end
            end
          end
        end
      endcase
    end
  end

  assert_read_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
  assert_no_read_while_pending_R8: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT && !mem_rsp_valid) |=> !mem_req);
  assert_read_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_fault_zero_result_R10: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> (pa == '0 && attr == '0));
  assert_fault_coded_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> (fault == (fault_kind != 2'd0)));
  assert_busy_holds_va_R9: assert property (@(posedge clk) disable iff (rst)
    !req_ready |=> $stable(va_q));
endmodule

// File: tb/tablewalk_unit_tb_top.sv
`timescale 1ns/1ps
module tablewalk_unit_tb_top;
  localparam int CTX_W = 8;
  localparam logic [29:0] ROOT = 30'h100;

  typedef struct packed {
    logic        flt;
    logic [1:0]  kind;
    logic [1:0]  lvl;
    logic [35:0] pa;
    logic [5:0]  attr;
  } res_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [31:0] req_va = '0;
  logic [CTX_W-1:0] req_ctx = '0;
  logic [29:0] root_ptr = ROOT;
  logic mem_req;
  logic [35:0] mem_addr;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic done, fault;
  logic [1:0] fault_kind, walk_level;
  logic [35:0] pa;
  logic [5:0] attr;

  int checks = 0;
  int errors = 0;
  logic [31:0] mem_m [logic [35:0]];
  logic [35:0] exp_addr_q [$];
  res_t exp_res_q [$];

  always #2 clk = ~clk;

  tablewalk_unit #(.CTX_W(CTX_W)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_ctx(req_ctx), .root_ptr(root_ptr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .fault(fault),
    .fault_kind(fault_kind), .walk_level(walk_level), .pa(pa), .attr(attr)
  );

  function automatic logic [31:0] rd(input logic [35:0] a);
    return mem_m.exists(a) ? mem_m[a] : 32'h0;
  endfunction

  function automatic logic [35:0] slot(input logic [35:0] base, input int idx);
    return base + 36'(idx) * 36'd4;
  endfunction

  function automatic int va_idx(input logic [31:0] va, input int lvl);
    if (lvl == 1) return int'(va[31:24]);
    if (lvl == 2) return int'(va[23:18]);
    return int'(va[17:12]);
  endfunction

  function automatic logic [31:0] mk_ptr(input logic [35:0] base);
    return {base[35:6], 2'b01};
  endfunction

  function automatic logic [31:0] mk_leaf(input logic [23:0] ppn, input logic [5:0] at);
    return {ppn, at, 2'b10};
  endfunction

  task automatic check(input string rq, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // Reference walk computed from the requirement text.
  task automatic expect_walk(input logic [CTX_W-1:0] ctx, input logic [31:0] va);
    logic [35:0] a, mask;
    logic [31:0] e;
    res_t r;
    a = slot({ROOT, 6'b0}, int'(ctx));
    r = '0;
    for (int lvl = 0; lvl < 4; lvl++) begin
      exp_addr_q.push_back(a);
      e = rd(a);
      r.lvl = 2'(lvl);
      if (e[1:0] == 2'd0) begin r.flt = 1; r.kind = 2'd1; break; end
      if (e[1:0] == 2'd3) begin r.flt = 1; r.kind = 2'd2; break; end
      if (e[1:0] == 2'd2) begin
        mask = (lvl == 0) ? 36'hFFFFFFFF : (lvl == 1) ? 36'hFFFFFF :
               (lvl == 2) ? 36'h3FFFF : 36'hFFF;
        r.pa = ({e[31:8], 12'h000} & ~mask) | ({4'h0, va} & mask);
        r.attr = e[7:2];
        break;
      end
      if (lvl == 3) begin r.flt = 1; r.kind = 2'd3; break; end
      a = slot({e[31:2], 6'b0}, va_idx(va, lvl + 1));
    end
    exp_res_q.push_back(r);
  endtask

  task automatic send(input logic [CTX_W-1:0] ctx, input logic [31:0] va, input bit junk);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    expect_walk(ctx, va);
    req_valid = 1'b1; req_ctx = ctx; req_va = va;
    @(negedge clk);
    if (junk) begin
      req_va = 32'hFFFF_FFFF; req_ctx = 8'hFF;   // R9: offered while busy
      @(negedge clk);
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  // Memory responder: two cycles of latency after the pulse.
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req) begin
        logic [31:0] d;
        d = rd(mem_addr);
        @(posedge clk);
        @(posedge clk);
        #1 mem_rsp_valid = 1'b1; mem_rsp_data = d;
        @(posedge clk);
        #1 mem_rsp_valid = 1'b0;
      end
    end
  end

  // Monitor / scoreboard.
  bit outst = 0;
  bit prev_done = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_rsp_valid) outst = 0;
      if (mem_req) begin
        checks++;
        if (outst) begin errors++; $display("FAIL R8 actual=second_read expected=none_pending"); end
        outst = 1;
        if (exp_addr_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R9 actual=read %h expected=no_read", mem_addr);
        end else begin
          check("R2 R3 read address", 48'(mem_addr), 48'(exp_addr_q.pop_front()));
        end
      end
      if (done) begin
        res_t e;
        check("R10 done pulse", 48'(prev_done), 48'(0));
        check("R9 ready on done", 48'(req_ready), 48'(1));
        if (exp_res_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R9 actual=done expected=no_result");
        end else begin
          e = exp_res_q.pop_front();
          check("R4 R5 fault/kind", 48'({fault, fault_kind}), 48'({e.flt, e.kind}));
          check("R4 R6 level", 48'(walk_level), 48'(e.lvl));
          check("R6 R10 pa", 48'(pa), 48'(e.pa));
          check("R7 R10 attr", 48'(attr), 48'(e.attr));
        end
      end
      prev_done = done;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R8 watchdog actual=hung expected=complete");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [35:0] l0, b1, b2, b3;
    l0 = {ROOT, 6'b0};
    b1 = 36'h0_0001_0000; b2 = 36'h0_0002_0000; b3 = 36'h0_0003_0000;
    mem_m[slot(l0, 5)] = mk_ptr(b1);
    mem_m[slot(l0, 7)] = mk_leaf(24'h9A5C3E, 6'h01);
    mem_m[slot(b1, 8'h12)] = mk_ptr(b2);
    mem_m[slot(b1, 8'h7F)] = mk_leaf(24'hFEDCBA, 6'h3F);
    mem_m[slot(b1, 8'h33)] = 32'h0000_00F3;
    mem_m[slot(b2, 6'h0D)] = mk_ptr(b3);
    mem_m[slot(b2, 6'h10)] = mk_leaf(24'h123456, 6'h15);
    mem_m[slot(b3, 6'h05)] = mk_leaf(24'hABCDE1, 6'h2D);
    mem_m[slot(b3, 6'h07)] = mk_ptr(36'h0_0004_0000);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ready", 48'(req_ready), 48'(1));
    check("R1 done", 48'(done), 48'(0));
    check("R1 mem_req", 48'(mem_req), 48'(0));

    send(8'd5, 32'h1234_5678, 1'b1);  // R6 4 KB page, R9 junk while busy
    send(8'd5, 32'h1240_0ABC, 1'b0);  // R6 256 KB page
    send(8'd5, 32'h7F00_0123, 1'b0);  // R6 16 MB page
    send(8'd7, 32'hDEAD_BEEF, 1'b1);  // R6 4 GB page
    send(8'd5, 32'h1280_0000, 1'b0);  // R4 invalid at level 2
    send(8'd5, 32'h3300_0000, 1'b0);  // R4 reserved type at level 1
    send(8'd5, 32'h1234_7000, 1'b0);  // R5 pointer at level 3
    send(8'd9, 32'h0000_1000, 1'b0);  // R4 invalid at level 0
    send(8'd5, 32'h1234_5FFF, 1'b0);  // R3 R6 same page, offset edge

    repeat (40) @(negedge clk);
    check("R9 no leftover reads", 48'(exp_addr_q.size()), 48'(0));
    check("R9 no leftover results", 48'(exp_res_q.size()), 48'(0));
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule